// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a 10-bit successive-approximation analog-to-digital converter. Software configures it through four byte-wide registers. It picks one of twelve analog inputs and a reference source, then sets a go/done bit to start a conversion. The controller then runs a binary search. On each enabled conversion-clock step it presents a trial code to the DAC and reads back one comparator bit. When the search ends it stores the result, clears go/done and raises an interrupt flag.

The analog mux, DAC, comparator and sample-and-hold are outside this block. They are seen only as a channel select, reference selects, a trial code and a compare bit. The conversion steps are gated by `conv_ce`, a separate enable pulse, so the search can advance from an independent conversion clock rather than from every core cycle.

Register map (`reg_addr`):
- Address 0, control: bit 0 enable, bit 1 go/done, bits 5:2 channel code.
- Address 1, config: bits 1:0 reference select, bit 7 interrupt flag.
- Address 2, result high: bits 1:0 hold result bits 9:8, bits 7:2 read as zero.
- Address 3, result low: result bits 7:0.

State machine:
- `ST_IDLE` moves to `ST_RUN` on *start*, a control write with both enable and go set.
- `ST_RUN` moves back to `ST_IDLE` on *abort*, a control write in which enable or go is 0.
- `ST_RUN` moves to `ST_STORE` on *finish*, a `conv_ce` step that resolves the last bit.
- `ST_STORE` moves to `ST_IDLE` unconditionally, after one cycle in which the result is written.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control and config registers read 0, `irq` is 0, `dac_code` is 0 and the controller is idle. The result registers are not cleared by reset.
- R2: The cycle after a start, `dac_code` is 0x200, which is the MSB trial with all other bits zero.
- R3: The search advances exactly one bit per clock edge with `conv_ce` high, from MSB to LSB. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above the trial code. Without `conv_ce`, `dac_code` holds.
- R4: At the end of a conversion the result is stored, go/done (control bit 1) reads 0 and `irq` is 1. For a valid channel the stored result equals the input value under test.
- R5: Writing the control register with go=0 during a conversion aborts it. The result is unchanged, `irq` stays 0 and `dac_code` returns to 0.
- R6: Writing go=1 with enable=0 (control bit 0) has no effect: go/done reads 0 and no conversion or flag follows.
- R7: The result is right-justified. Address 2 bits 1:0 hold result bits 9:8 with bits 7:2 reading zero, and address 3 holds result bits 7:0.
- R8: A channel code of 12 to 15 drives `ch_valid` low, and the conversion stores a result of 0 while still clearing go/done and setting the flag.
- R9: The interrupt flag (config bit 7, also `irq`) stays set until software writes 0 to it. Writing 1 never sets it.
- R10: `ch_sel` follows control bits 5:2. `ref_pos_ext` follows config bit 0 and `ref_neg_ext` follows config bit 1 (1 selects the external pin, 0 the supply rail).
- R11: A reset during a conversion aborts it and returns the registers to their R1 state, while the result registers keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_ce | input | 1 | Conversion-clock enable, one search step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ch_sel | output | 4 | Analog input select code |
| ch_valid | output | 1 | Channel code names an existing input |
| ref_pos_ext | output | 1 | Positive reference from external pin |
| ref_neg_ext | output | 1 | Negative reference from external pin |
| dac_code | output | 10 | Trial code to the DAC, 0 when not converting |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench drives input values at the extremes (0, 1023, and the 0x1FF/0x200 boundary). A design that starts the search at the wrong bit, or that treats equality as "below", would return a value off by one step there. Stepping is held back and then pulsed one `conv_ce` at a time so that the trial code can be compared after every step. A design that advanced on the core clock instead would show this as wrong intermediate codes. Aborts, go writes while disabled, and a reset in mid-search are each followed by a check that the result, the go bit and the flag are unchanged, which catches a design that stores partial results or leaves go set. Channel codes above 11 confirm a forced zero result, and writes of 1 to the flag confirm that it cannot be set by software.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STORE = 2'd2
    } sar_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CFG    = 2'd1;
    localparam logic [1:0] ADDR_RES_HI = 2'd2;
    localparam logic [1:0] ADDR_RES_LO = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_GO   = 1;
    localparam int CH_LSB   = 2;
    localparam int BIT_FLAG = 7;

endpackage

// File: rtl/sar_adc_search.sv
module sar_adc_search #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] acc_code,
    output logic             last_bit
);

    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] acc_q;

    // one-hot mask walks from MSB to LSB; acc keeps accepted bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            acc_q  <= '0;
        end else if (load) begin
            mask_q <= {1'b1, {(RES_W-1){1'b0}}};
            acc_q  <= '0;
        end else if (step) begin
            if (cmp_in) begin
                acc_q <= acc_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

    assign trial_code = acc_q | mask_q;
    assign acc_code   = acc_q;
    assign last_bit   = mask_q[0];

endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             store,
    input  logic [RES_W-1:0] store_val,
    output logic [7:0]       rdata,
    output logic             enable,
    output logic             go,
    output logic [CH_W-1:0]  ch_field,
    output logic [1:0]       ref_cfg,
    output logic             flag
);

    logic             wr_ctrl;
    logic             wr_cfg;
    logic [RES_W-1:0] res_q;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_cfg  = wr_en && (addr == ADDR_CFG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            go       <= 1'b0;
            ch_field <= '0;
            ref_cfg  <= '0;
            flag     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                enable   <= wdata[BIT_EN];
                ch_field <= wdata[CH_LSB +: CH_W];
            end
            if (store) begin
                go <= 1'b0;
            end else if (wr_ctrl) begin
                go <= wdata[BIT_GO] & wdata[BIT_EN];
            end
            if (wr_cfg) begin
                ref_cfg <= wdata[1:0];
            end
            if (store) begin
                flag <= 1'b1;
            end else if (wr_cfg && !wdata[BIT_FLAG]) begin
                flag <= 1'b0;
            end
        end
    end

    // result pair is deliberately outside the reset
    always_ff @(posedge clk) begin
        if (store) begin
            res_q <= store_val;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[BIT_EN]            = enable;
                rdata[BIT_GO]            = go;
                rdata[CH_LSB +: CH_W]    = ch_field;
            end
            ADDR_CFG: begin
                rdata[1:0]      = ref_cfg;
                rdata[BIT_FLAG] = flag;
            end
            ADDR_RES_HI: rdata = 8'(res_q >> 8);
            ADDR_RES_LO: rdata = res_q[7:0];
        endcase
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CH_W   = 4,
    parameter int NUM_CH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_ce,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [CH_W-1:0]  ch_sel,
    output logic             ch_valid,
    output logic             ref_pos_ext,
    output logic             ref_neg_ext,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_in,
    output logic             irq
);

    sar_state_e       state_q, state_d;
    logic             ctrl_wr, go_req, start, abort;
    logic             load, step, store;
    logic             enable, go, flag;
    logic [1:0]       ref_cfg;
    logic [CH_W-1:0]  ch_field;
    logic [RES_W-1:0] trial_code, acc_code, store_val;
    logic             last_bit;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign go_req  = reg_wdata[BIT_EN] & reg_wdata[BIT_GO];
    assign start   = ctrl_wr && go_req && (state_q == ST_IDLE);
    assign abort   = ctrl_wr && !go_req && (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (step && last_bit) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        store    = 1'b0;
        dac_code = '0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_RUN: begin
                step     = conv_ce && !abort;
                dac_code = trial_code;
            end
            ST_STORE: store = 1'b1;
            default:  ;
        endcase
    end

    assign ch_valid    = int'(ch_field) < NUM_CH;
    assign ch_sel      = ch_field;
    assign store_val   = ch_valid ? acc_code : '0;
    assign ref_pos_ext = ref_cfg[0];
    assign ref_neg_ext = ref_cfg[1];
    assign irq         = flag;

    sar_adc_search #(.RES_W(RES_W)) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .acc_code   (acc_code),
        .last_bit   (last_bit)
    );

    sar_adc_regs #(.RES_W(RES_W), .CH_W(CH_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .store     (store),
        .store_val (store_val),
        .rdata     (reg_rdata),
        .enable    (enable),
        .go        (go),
        .ch_field  (ch_field),
        .ref_cfg   (ref_cfg),
        .flag      (flag)
    );

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk
    import sar_adc_pkg::*;
#(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_ce,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input sar_state_e       state_q,
    input logic             start,
    input logic             abort,
    input logic             store,
    input logic             go,
    input logic             ch_valid,
    input logic [RES_W-1:0] dac_code,
    input logic             irq
);

    logic ctrl_wr_off;
    logic flag_clear_wr;

    assign ctrl_wr_off   = reg_wr && (reg_addr == ADDR_CTRL) && !reg_wdata[BIT_EN];
    assign flag_clear_wr = reg_wr && (reg_addr == ADDR_CFG) && !reg_wdata[BIT_FLAG];

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_IDLE && !irq)); // R1
    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (dac_code == {1'b1, {(RES_W-1){1'b0}}})); // R2
    AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !conv_ce && !abort) |=> $stable(dac_code)); // R3
    AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (!go && irq)); // R4
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !irq) |=> (!irq && state_q == ST_IDLE)); // R5
    AST_DISABLED_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_off |=> !go); // R6
    AST_RES_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_RES_HI) |-> ((reg_rdata >> (RES_W-8)) == 8'd0)); // R7
    AST_INVALID_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !ch_valid && reg_addr == ADDR_RES_LO) |=>
            (reg_addr != ADDR_RES_LO || reg_rdata == 8'd0)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_clear_wr) |=> irq); // R9

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_ce   (conv_ce),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .state_q   (state_q),
    .start     (start),
    .abort     (abort),
    .store     (store),
    .go        (go),
    .ch_valid  (ch_valid),
    .dac_code  (dac_code),
    .irq       (irq)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       conv_ce;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] ch_sel;
    logic       ch_valid, ref_pos_ext, ref_neg_ext, cmp_in, irq;
    logic [9:0] dac_code;

    logic [9:0] vin [16];
    int total = 0;
    int bad   = 0;
    int ce_mode = 0;

    always #10 clk = ~clk;

    // comparator model: selected input at or above the trial code
    assign cmp_in = ch_valid && (vin[ch_sel] >= dac_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .conv_ce(conv_ce), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_sel(ch_sel), .ch_valid(ch_valid), .ref_pos_ext(ref_pos_ext),
        .ref_neg_ext(ref_neg_ext), .dac_code(dac_code), .cmp_in(cmp_in), .irq(irq)
    );

    function automatic logic [9:0] exp_result(input int ch);
        return (ch < 12) ? vin[ch] : 10'd0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_res(output logic [9:0] r);
        logic [7:0] h, l;
        rd(2'd2, h);
        rd(2'd3, l);
        r = {h[1:0], l};
        check("R7 high bits 7:2 zero", int'(h[7:2]), 0);
    endtask

    task automatic wait_done(output bit ok);
        logic [7:0] d;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rd(2'd0, d);
            if (!d[1]) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic convert(input int ch, output logic [9:0] r);
        bit ok;
        wr(2'd0, 8'((ch << 2) | 3));
        wait_done(ok);
        check("R4 go cleared at end", int'(ok), 1);
        check("R4 flag set at end", int'(irq), 1);
        read_res(r);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (ce_mode == 1)      conv_ce = 1'b1;
            else if (ce_mode == 2) conv_ce = (($urandom % 3) == 0);
            else if (ce_mode == 0) conv_ce = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [9:0] r, prev;
        void'($urandom(32'h5A17));
        rst_n = 1'b0; conv_ce = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
        for (int i = 0; i < 16; i++) vin[i] = 10'($urandom % 1024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 control after reset", int'(d), 0);
        rd(2'd1, d); check("R1 config after reset", int'(d), 0);
        check("R1 irq after reset", int'(irq), 0);
        check("R1 dac after reset", int'(dac_code), 0);

        // R10 selects
        wr(2'd1, 8'h01);
        check("R10 pos ext", int'(ref_pos_ext), 1); check("R10 neg rail", int'(ref_neg_ext), 0);
        wr(2'd1, 8'h02);
        check("R10 pos rail", int'(ref_pos_ext), 0); check("R10 neg ext", int'(ref_neg_ext), 1);
        wr(2'd0, 8'(7 << 2));
        check("R10 ch_sel", int'(ch_sel), 7); check("R8 ch 7 valid", int'(ch_valid), 1);
        wr(2'd0, 8'(13 << 2));
        check("R8 ch 13 invalid", int'(ch_valid), 0);

        // R2/R3 stepwise search
        vin[3] = 10'h300;
        ce_mode = 0;
        wr(2'd0, 8'((3 << 2) | 3));
        check("R2 first trial", int'(dac_code), 'h200);
        repeat (4) @(negedge clk);
        check("R3 hold without ce", int'(dac_code), 'h200);
        ce_mode = 3;
        conv_ce = 1'b1; @(negedge clk); conv_ce = 1'b0;
        check("R3 step keeps msb", int'(dac_code), 'h300);
        conv_ce = 1'b1; @(negedge clk); conv_ce = 1'b0;
        check("R3 equal keeps bit", int'(dac_code), 'h380);
        ce_mode = 1;
        begin
            bit ok;
            wait_done(ok);
            check("R4 go cleared", int'(ok), 1);
        end
        read_res(r);
        check("R4 result 0x300", int'(r), 'h300);
        rd(2'd2, d); check("R7 high reg", int'(d), 'h03);
        rd(2'd3, d); check("R7 low reg", int'(d), 'h00);

        // R9 flag stickiness
        check("R9 flag set", int'(irq), 1);
        wr(2'd1, 8'h80); check("R9 write 1 keeps", int'(irq), 1);
        wr(2'd1, 8'h00); check("R9 write 0 clears", int'(irq), 0);
        wr(2'd1, 8'h80); check("R9 write 1 no set", int'(irq), 0);

        // boundary values
        vin[0] = 10'd0; vin[11] = 10'h3FF; vin[5] = 10'h1FF; vin[6] = 10'h200;
        convert(0, r);  check("R4 zero input", int'(r), 0);        wr(2'd1, 8'h00);
        convert(11, r); check("R4 full scale", int'(r), 'h3FF);    wr(2'd1, 8'h00);
        rd(2'd3, d);    check("R7 low full", int'(d), 'hFF);
        convert(5, r);  check("R4 0x1FF", int'(r), 'h1FF);        wr(2'd1, 8'h00);
        convert(6, r);  check("R4 0x200", int'(r), 'h200);        wr(2'd1, 8'h00);

        // R8 invalid channels
        vin[12] = 10'h155;
        convert(12, r); check("R8 ch 12 zero", int'(r), 0);        wr(2'd1, 8'h00);
        vin[15] = 10'h3FF;
        convert(15, r); check("R8 ch 15 zero", int'(r), 0);        wr(2'd1, 8'h00);

        // R5 abort
        vin[9] = 10'h3FF;
        convert(9, prev); wr(2'd1, 8'h00);
        vin[2] = 10'h2AA;
        wr(2'd0, 8'((2 << 2) | 3));
        repeat (3) @(negedge clk);
        wr(2'd0, 8'((2 << 2) | 1));
        check("R5 dac idle after abort", int'(dac_code), 0);
        repeat (20) @(negedge clk);
        rd(2'd0, d); check("R5 go after abort", int'(d[1]), 0);
        check("R5 no flag", int'(irq), 0);
        read_res(r); check("R5 result kept", int'(r), int'(prev));

        // R6 go while disabled
        wr(2'd0, 8'((4 << 2) | 2));
        repeat (20) @(negedge clk);
        rd(2'd0, d); check("R6 control reads disabled idle", int'(d), 4 << 2);
        check("R6 no flag", int'(irq), 0);
        check("R6 dac idle", int'(dac_code), 0);
        read_res(r); check("R6 result kept", int'(r), int'(prev));

        // random conversions
        for (int n = 0; n < 40; n++) begin
            int ch;
            logic [1:0] cfg;
            ch = int'($urandom % 16);
            vin[ch] = 10'($urandom % 1024);
            ce_mode = 1 + int'($urandom % 2);
            cfg = 2'($urandom % 4);
            wr(2'd1, {6'd0, cfg});
            check("R10 random pos ref", int'(ref_pos_ext), int'(cfg[0]));
            check("R10 random neg ref", int'(ref_neg_ext), int'(cfg[1]));
            convert(ch, r);
            check(ch < 12 ? "R4 random result" : "R8 random invalid", int'(r), int'(exp_result(ch)));
        end
        wr(2'd1, 8'h00);

        // R11 reset mid conversion
        ce_mode = 1;
        read_res(prev);
        vin[1] = 10'h0F0;
        wr(2'd0, 8'((1 << 2) | 3));
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, d); check("R11 control cleared", int'(d), 0);
        rd(2'd1, d); check("R11 config cleared", int'(d), 0);
        check("R11 dac idle", int'(dac_code), 0);
        repeat (20) @(negedge clk);
        check("R11 no flag", int'(irq), 0);
        read_res(r); check("R11 result kept", int'(r), int'(prev));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule